// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits at the home node of a small shared-memory system with a fixed number of caching agents. For every memory block it holds a sharer mask, with one bit per agent, and one exclusive-owner flag. An agent that misses in its cache sends a read-miss or write-miss request here. The controller looks up the entry for the block. It sends recall or invalidate messages only to the agents that the mask names, collects one reply from each of them, keeps its behavioural memory current and returns the block to the requester.

All four channels use a valid/ready handshake: requests, outbound messages, per-agent replies and responses. The message channel has one valid/ready pair per agent and a kind and address shared by all agents. All targeted agents are signalled in the same cycle. The controller handles one transaction at a time and takes a new request only when it is idle.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `msg_valid` and `rsp_valid` are 0, every entry has an empty sharer mask and a clear owner flag, and memory block b holds the value b.
- R2: A read miss to a block whose owner flag is clear sends no message and responds with the memory contents. The requester is added to the sharer mask.
- R3: A read miss to an owned block sends one message of kind 2 (recall, keep shared) to the owner only. The reply data is written to memory and returned to the requester. Afterwards the block has a clear owner flag, and both the old owner and the requester are sharers.
- R4: A write miss to a block whose owner flag is clear sends a message of kind 1 (invalidate) to every sharer other than the requester. All these messages are raised in the same cycle. The response carries the memory contents.
- R5: The response is not raised until one reply has been accepted from every agent that was sent a message.
- R6: A write miss to an owned block sends one message of kind 3 (recall and invalidate) to the owner. The reply data is written to memory and returned to the requester.
- R7: The requester is never a target of a message, even when it is already a sharer.
- R8: After a write miss the requester is the only sharer and the owner flag is set. A later read by another agent therefore recalls from that requester alone.
- R9: `req_ready` stays 0 from the cycle after a request is accepted until the response has been accepted. It returns to 1 in the cycle after the response is accepted.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold. `rsp_agent` equals the requester, and `msg_addr` equals the requested block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle, takes request |
| req_agent | input | AID_W | Requesting agent index |
| req_addr | input | ADDR_W | Block index |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| msg_valid | output | N_AGENTS | Per-agent message strobe |
| msg_ready | input | N_AGENTS | Per-agent message accept |
| msg_kind | output | 2 | 1 invalidate, 2 recall keep shared, 3 recall and invalidate |
| msg_addr | output | ADDR_W | Block the message concerns |
| ack_valid | input | N_AGENTS | Per-agent reply strobe |
| ack_ready | output | N_AGENTS | Per-agent reply accept |
| ack_data | input | N_AGENTS*DATA_W | Per-agent reply data (used on recalls) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response accepted |
| rsp_agent | output | AID_W | Agent the response is for |
| rsp_data | output | DATA_W | Block data |

## Verification
The bench builds the controller with four agents, eight blocks and 16-bit data. With four agents, a write miss can face three sharers at once, so the same-cycle fan-out and the collection of several replies are exercised. With only eight blocks, random traffic keeps returning to blocks that are already shared or owned, so the traffic covers all four miss cases and upgrades from a shared copy. Random reply delays and response stalls test that the response waits for the last reply and holds steady while it is stalled.

// File: rtl/dir_pkg.sv
// Shared types for the home directory controller.
// Assumes: message kind codes are decoded by the agents' cache controllers.
package dir_pkg;

    typedef enum logic [1:0] {
        MSG_NONE       = 2'd0,
        MSG_INVAL      = 2'd1,
        MSG_RECALL_SH  = 2'd2,
        MSG_RECALL_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_COLLECT,
        ST_RESPOND
    } ctl_state_e;

endpackage

// File: rtl/dir_entry_store.sv
// Directory entry array: one sharer mask and one owner flag per block.
// Assumes: one read port (combinational) and one write port, reset clears all.
module dir_entry_store #(
    parameter int N_AGENTS = 4,
    parameter int N_BLOCKS = 8,
    localparam int ADDR_W  = $clog2(N_BLOCKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [N_AGENTS-1:0] rd_sharers,
    output logic                rd_owned,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [N_AGENTS-1:0] wr_sharers,
    input  logic                wr_owned
);

    logic [N_AGENTS-1:0] sharers_q [N_BLOCKS];
    logic [N_BLOCKS-1:0] owned_q;

    // Entry update: clear on reset, overwrite on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                sharers_q[b] <= '0;
            end
            owned_q <= '0;
        end else if (wr_en) begin
            sharers_q[wr_addr] <= wr_sharers;
            owned_q[wr_addr]   <= wr_owned;
        end
    end

    // Read port.
    always_comb begin
        rd_sharers = sharers_q[rd_addr];
        rd_owned   = owned_q[rd_addr];
    end

    AST_OWNED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_owned |-> $countones(wr_sharers) == 1); // R8

endmodule

// File: rtl/dir_data_mem.sv
// Behavioural block memory at the home node.
// Assumes: block b is reset to the value b; one read and one write port.
module dir_data_mem #(
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int ADDR_W  = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [N_BLOCKS];

    // Storage: index pattern on reset, write on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                mem_q[b] <= DATA_W'(b);
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read port.
    always_comb rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dir_agent_port.sv
// Per-agent message/reply tracker: raises the message, then waits for one reply.
// Assumes: start arrives only when this port is free; reply accepted after message.
module dir_agent_port (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic target,
    output logic msg_valid,
    input  logic msg_ready,
    input  logic ack_valid,
    output logic ack_ready,
    output logic ack_fire,
    output logic busy
);

    logic msg_pend;
    logic ack_pend;

    // Pending flags: armed on start, cleared by each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_pend <= 1'b0;
            ack_pend <= 1'b0;
        end else if (start && target) begin
            msg_pend <= 1'b1;
            ack_pend <= 1'b1;
        end else begin
            if (msg_pend && msg_ready) msg_pend <= 1'b0;
            if (ack_fire)              ack_pend <= 1'b0;
        end
    end

    // Handshake outputs.
    always_comb begin
        msg_valid = msg_pend;
        ack_ready = ack_pend && !msg_pend;
        ack_fire  = ack_ready && ack_valid;
        busy      = msg_pend || ack_pend;
    end

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9

endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node full-map directory controller.
// Looks up the entry of a missed block, sends recall/invalidate messages to
// the recorded agents only, gathers their replies, updates memory and answers.
// Assumes: one transaction at a time; no replacement write-backs; no races.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int AID_W   = $clog2(N_AGENTS),
    localparam int ADDR_W  = $clog2(N_BLOCKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [AID_W-1:0]           req_agent,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    output logic [N_AGENTS-1:0]        msg_valid,
    input  logic [N_AGENTS-1:0]        msg_ready,
    output logic [1:0]                 msg_kind,
    output logic [ADDR_W-1:0]          msg_addr,
    input  logic [N_AGENTS-1:0]        ack_valid,
    output logic [N_AGENTS-1:0]        ack_ready,
    input  logic [N_AGENTS*DATA_W-1:0] ack_data,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic [AID_W-1:0]           rsp_agent,
    output logic [DATA_W-1:0]          rsp_data
);

    ctl_state_e          state;
    logic [AID_W-1:0]    cur_agent;
    logic [ADDR_W-1:0]   cur_addr;
    logic                cur_write;
    msg_kind_e           cur_kind;
    logic [DATA_W-1:0]   rsp_q;

    logic [N_AGENTS-1:0] req_mask;
    logic [N_AGENTS-1:0] ent_sharers;
    logic                ent_owned;
    logic [DATA_W-1:0]   mem_rdata;
    logic [N_AGENTS-1:0] tgt_calc;
    msg_kind_e           kind_calc;
    logic                need_msg;
    logic                start;
    logic [N_AGENTS-1:0] ack_fire;
    logic [N_AGENTS-1:0] busy;
    logic [DATA_W-1:0]   recall_data;
    logic                mem_we;
    logic                ent_we;
    logic [N_AGENTS-1:0] ent_wr_sharers;

    // Lookup decode: targets exclude the requester; kind follows miss type and owner flag.
    always_comb begin
        req_mask  = N_AGENTS'(1) << cur_agent;
        tgt_calc  = ent_sharers & ~req_mask;
        need_msg  = (|tgt_calc) && (cur_write || ent_owned);
        if (!cur_write)     kind_calc = MSG_RECALL_SH;
        else if (ent_owned) kind_calc = MSG_RECALL_INV;
        else                kind_calc = MSG_INVAL;
        start     = (state == ST_LOOKUP) && need_msg;
    end

    // Reply data select: data of whichever agent's reply is accepted this cycle.
    always_comb begin
        recall_data = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (ack_fire[k]) recall_data = ack_data[k*DATA_W +: DATA_W];
        end
    end

    // Memory and entry write strobes.
    always_comb begin
        mem_we         = (state == ST_COLLECT) && (cur_kind != MSG_INVAL) && (|ack_fire);
        ent_we         = (state == ST_RESPOND) && rsp_ready;
        ent_wr_sharers = cur_write ? req_mask : (ent_sharers | req_mask);
    end

    // Transaction sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_agent <= '0;
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_kind  <= MSG_NONE;
            rsp_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_agent <= req_agent;
                        cur_addr  <= req_addr;
                        cur_write <= req_write;
                        state     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    cur_kind <= kind_calc;
                    if (need_msg) begin
                        state <= ST_COLLECT;
                    end else begin
                        rsp_q <= mem_rdata;
                        state <= ST_RESPOND;
                    end
                end
                ST_COLLECT: begin
                    if (mem_we) rsp_q <= recall_data;
                    if (busy == '0) begin
                        if (cur_kind == MSG_INVAL) rsp_q <= mem_rdata;
                        state <= ST_RESPOND;
                    end
                end
                ST_RESPOND: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    dir_entry_store #(
        .N_AGENTS (N_AGENTS),
        .N_BLOCKS (N_BLOCKS)
    ) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (cur_addr),
        .rd_sharers (ent_sharers),
        .rd_owned   (ent_owned),
        .wr_en      (ent_we),
        .wr_addr    (cur_addr),
        .wr_sharers (ent_wr_sharers),
        .wr_owned   (cur_write)
    );

    dir_data_mem #(
        .N_BLOCKS (N_BLOCKS),
        .DATA_W   (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (cur_addr),
        .rd_data (mem_rdata),
        .wr_en   (mem_we),
        .wr_addr (cur_addr),
        .wr_data (recall_data)
    );

    for (genvar k = 0; k < N_AGENTS; k++) begin : g_port
        dir_agent_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .target    (tgt_calc[k]),
            .msg_valid (msg_valid[k]),
            .msg_ready (msg_ready[k]),
            .ack_valid (ack_valid[k]),
            .ack_ready (ack_ready[k]),
            .ack_fire  (ack_fire[k]),
            .busy      (busy[k])
        );
    end

    // Port outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESPOND);
        rsp_agent = cur_agent;
        rsp_data  = rsp_q;
        msg_kind  = cur_kind;
        msg_addr  = cur_addr;
    end

    AST_RSP_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy == '0); // R5
    AST_NO_SELF_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid & req_mask) == '0); // R7
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && msg_valid == '0); // R9

endmodule

// File: tb/dir_home_ctrl_tb.sv
// Bench: models the agents' caches and a reference directory, mixing directed
// corner cases with seeded random misses.
module dir_home_ctrl_tb;

    localparam int NA = 4;
    localparam int NB = 8;
    localparam int DW = 16;
    localparam int AW = $clog2(NA);
    localparam int BW = $clog2(NB);
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [AW-1:0]     req_agent = '0;
    logic [BW-1:0]     req_addr = '0;
    logic              req_write = 1'b0;
    logic [NA-1:0]     msg_valid;
    logic [NA-1:0]     msg_ready = '1;
    logic [1:0]        msg_kind;
    logic [BW-1:0]     msg_addr;
    logic [NA-1:0]     ack_valid = '0;
    logic [NA-1:0]     ack_ready;
    logic [NA*DW-1:0]  ack_data = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [AW-1:0]     rsp_agent;
    logic [DW-1:0]     rsp_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Cache model: 0 invalid, 1 shared, 2 modified.
    int            cstate [NA][NB];
    logic [DW-1:0] cdata  [NA][NB];
    logic [NA-1:0] dsh    [NB];
    logic          down   [NB];
    logic [DW-1:0] mmem   [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_home_ctrl #(.N_AGENTS(NA), .N_BLOCKS(NB), .DATA_W(DW)) u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_agent, .req_addr, .req_write,
        .msg_valid, .msg_ready, .msg_kind, .msg_addr,
        .ack_valid, .ack_ready, .ack_data,
        .rsp_valid, .rsp_ready, .rsp_agent, .rsp_data
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int owner_of(input int b);
        for (int k = 0; k < NA; k++) if (cstate[k][b] == 2) return k;
        return 0;
    endfunction

    function automatic logic [NA-1:0] exp_targets(input int a, input int b, input bit w);
        logic [NA-1:0] t;
        t = dsh[b] & ~(NA'(1) << a);
        if (!w && !down[b]) t = '0;
        return t;
    endfunction

    // One miss transaction, checked against the reference model.
    task automatic run_txn(input int a, input int b, input bit w, input string ttag);
        logic [NA-1:0] etgt, seen, fired;
        int            wait_c [NA];
        int            first_c [NA];
        logic [1:0]    ekind;
        logic [DW-1:0] edata, held;
        int            hold, own;
        bit            got, done;
        string         dtag;
        etgt  = exp_targets(a, b, w);
        own   = owner_of(b);
        ekind = w ? (down[b] ? 2'd3 : 2'd1) : 2'd2;
        edata = down[b] ? cdata[own][b] : mmem[b];
        dtag  = w ? (down[b] ? "R6" : "R4") : (down[b] ? "R3" : "R2");
        seen = '0; fired = '0; got = 0; done = 0; hold = 0; held = '0;
        for (int k = 0; k < NA; k++) begin wait_c[k] = 0; first_c[k] = -1; end

        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before", req_ready, 1);
        req_valid = 1'b1; req_agent = AW'(a); req_addr = BW'(b); req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);

        for (int cyc = 0; cyc < 200 && !done; cyc++) begin
            for (int k = 0; k < NA; k++) if (fired[k]) ack_valid[k] = 1'b0;
            fired = '0;
            if (rsp_valid) begin
                if (!got) begin
                    got = 1;
                    chk(seen == etgt && ack_valid == '0, "R5 replies before response", seen, etgt);
                    for (int k = 0; k < NA; k++)
                        chk(wait_c[k] == 0, "R5 reply outstanding", wait_c[k], 0);
                    chk(rsp_data == edata, dtag, rsp_data, edata);
                    chk(rsp_agent == AW'(a), "R10 rsp_agent", rsp_agent, a);
                    held = rsp_data;
                    hold = $urandom_range(0, 2);
                end else begin
                    chk(rsp_data == held, "R10 held data", rsp_data, held);
                end
                if (hold == 0) begin rsp_ready = 1'b1; done = 1; end
                else hold--;
            end
            for (int k = 0; k < NA; k++) begin
                if (wait_c[k] > 0) begin
                    wait_c[k]--;
                    if (wait_c[k] == 0) begin
                        ack_valid[k] = 1'b1;
                        ack_data[k*DW +: DW] = (ekind == 2'd1) ? '0 : cdata[k][b];
                    end
                end
            end
            for (int k = 0; k < NA; k++) begin
                if (msg_valid[k] && !seen[k]) begin
                    seen[k] = 1'b1;
                    first_c[k] = cyc;
                    chk(msg_kind == ekind, ttag, msg_kind, ekind);
                    chk(msg_addr == BW'(b), "R10 msg_addr", msg_addr, b);
                    wait_c[k] = 1 + $urandom_range(0, 3);
                end
            end
            for (int k = 0; k < NA; k++) if (ack_valid[k] && ack_ready[k]) fired[k] = 1'b1;
            @(negedge clk);
        end
        if (!done) begin
            chk(1'b0, "R5 transaction timeout", 0, 1);
            rsp_ready = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        rsp_ready = 1'b0;
        ack_valid = '0;
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 idle after response", req_ready, 1);
        chk(seen == etgt, ttag, seen, etgt);
        chk((seen & (NA'(1) << a)) == '0, "R7 requester not targeted", seen, 0);
        if ($countones(etgt) > 1)
            for (int k = 0; k < NA; k++)
                if (etgt[k]) chk(first_c[k] == first_c[0] || !etgt[0] ? 1'b1 : 1'b0,
                                 "R4 same-cycle fan-out", first_c[k], first_c[0]);

        // Reference model update.
        if (!w) begin
            if (down[b]) begin
                cstate[own][b] = 1; mmem[b] = cdata[own][b]; down[b] = 1'b0;
            end
            dsh[b] = dsh[b] | (NA'(1) << a);
            cstate[a][b] = 1; cdata[a][b] = edata;
        end else begin
            if (down[b]) mmem[b] = cdata[own][b];
            for (int k = 0; k < NA; k++) if (etgt[k]) cstate[k][b] = 0;
            dsh[b] = NA'(1) << a; down[b] = 1'b1;
            cstate[a][b] = 2; cdata[a][b] = DW'($urandom);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int a, b;
        bit w;
        void'($urandom(32'd1234));
        for (int k = 0; k < NA; k++)
            for (int j = 0; j < NB; j++) begin cstate[k][j] = 0; cdata[k][j] = '0; end
        for (int j = 0; j < NB; j++) begin dsh[j] = '0; down[j] = 1'b0; mmem[j] = DW'(j); end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(msg_valid == '0, "R1 msg_valid", msg_valid, 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);

        // Directed: reset memory content, three sharers, fan-out, recalls, upgrade.
        run_txn(2, 5, 1'b0, "R1 memory pattern");
        run_txn(0, 3, 1'b0, "R2 clean read");
        run_txn(1, 3, 1'b0, "R2 clean read");
        run_txn(2, 3, 1'b0, "R2 clean read");
        run_txn(3, 3, 1'b1, "R4 invalidate sharers");
        run_txn(1, 3, 1'b0, "R8 recall from sole owner");
        run_txn(1, 3, 1'b1, "R7 upgrade excludes requester");
        run_txn(0, 3, 1'b1, "R6 recall and invalidate");
        run_txn(2, 3, 1'b0, "R3 recall keep shared");

        // Seeded random misses.
        for (int n = 0; n < 300; n++) begin
            do begin
                a = $urandom_range(0, NA-1);
                b = $urandom_range(0, NB-1);
                w = 1'($urandom_range(0, 1));
            end while ((w && cstate[a][b] == 2) || (!w && cstate[a][b] != 0));
            run_txn(a, b, w, w ? "R4 R6 targets" : "R2 R3 targets");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule